// File: doc/BRIEF.md
# Buffered Ten-Bit PWM Generator

This block drives one pulse-width-modulated output from a free-running 8-bit timer. A prescaler slows the timer's input clock. Two sub-count bits sit below the timer, so every timer increment takes four steps of the prescaler. Together the timer and the sub-count bits form a 10-bit time base, and the output is compared against a 10-bit duty value on that time base. The period comes from an 8-bit period value. The duty value comes from an 8-bit high part and a 2-bit low part.

The duty value is double-buffered. A write to the duty inputs is only copied into an internal shadow register at the end of a period, so a new duty value never changes a period that has already started. At each period boundary the time base returns to zero, the output goes high (unless the new shadow duty is zero), and the block raises a one-clock boundary pulse. An external postscaler can count this pulse. The output goes low again when the time base reaches the shadow duty value.

A 4-bit control field selects PWM operation. Any other setting stops the time base and holds the output low.

Top module: `dbuf_pwm`

## Requirements
- R1: One PWM period lasts (period_i + 1) × 4 × P clock cycles, where P is the prescale factor. `frame_o` is high for exactly the first clock cycle of every period, and the time base is zero during that cycle.
- R2: `prescale_i` selects P as follows: code 0 gives 1, code 1 gives 4, and codes 2 and 3 give 16.
- R3: At each period start, `pwm_o` goes high in the same cycle that `frame_o` goes high, provided the duty value copied at that boundary is nonzero.
- R4: With a copied duty value D = {duty_hi_i, duty_lo_i} that is smaller than (period_i + 1) × 4, `pwm_o` stays high for exactly D × P clock cycles from the period start and then stays low until the period ends.
- R5: If the copied duty value is zero, `pwm_o` stays low for the whole period.
- R6: If the copied duty value is at least (period_i + 1) × 4, `pwm_o` stays high for the whole period, and it stays high without a gap across consecutive periods.
- R7: A change to the duty inputs during a period does not affect that period. The change takes effect from the next period start.
- R8: PWM runs only when `mode_i[3:2]` = 2'b11. With any other mode value, `pwm_o` and `frame_o` are low from the next clock on, and the time base and the prescaler are held at zero. After PWM is enabled, `pwm_o` stays low until the first period boundary.
- R9: A synchronous active-high reset clears the time base, the prescaler, the shadow duty value, `pwm_o` and `frame_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 4 | Control field; PWM runs when bits [3:2] are 2'b11 |
| prescale_i | input | 2 | Prescale select (1, 4, 16, 16) |
| period_i | input | 8 | Period value |
| duty_hi_i | input | 8 | Upper eight bits of the duty value |
| duty_lo_i | input | 2 | Lower two bits of the duty value |
| pwm_o | output | 1 | PWM output |
| frame_o | output | 1 | One-cycle pulse at each period start |

## Verification
The hardest case to reach from the ports is a duty write that lands partway through a running period. The current period must keep its old width while the next period takes the new one. To reach it, the bench keeps a clock-accurate model of the position within the period and of the shadow duty value, and it rewrites the duty inputs a few cycles after a boundary. The same model also covers two other cases: disabling PWM while the output is high, and a duty value that covers the whole period.

// File: rtl/dbuf_pwm_pkg.sv
package dbuf_pwm_pkg;
    localparam int TMR_W = 8;
    localparam int SUB_W = 2;
    localparam int TB_W  = TMR_W + SUB_W;
    localparam int PS_W  = 4;

    typedef logic [TB_W-1:0] tbase_t;

    typedef struct packed {
        tbase_t tb;
        logic   frame;
    } tb_state_t;

    typedef struct packed {
        tbase_t shadow;
        logic   out;
    } latch_state_t;

    function automatic logic [PS_W-1:0] presc_last(input logic [1:0] sel);
        case (sel)
            2'd0:    return PS_W'(0);
            2'd1:    return PS_W'(3);
            default: return PS_W'(15);
        endcase
    endfunction
endpackage

// File: rtl/dbuf_pwm_prescaler.sv
module dbuf_pwm_prescaler
    import dbuf_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       step
);
    logic [PS_W-1:0] cnt_d, cnt_q;

    always_comb begin
        step  = run && (cnt_q >= presc_last(sel));
        cnt_d = cnt_q;
        if (!run || step) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    a_r8_presc_idle: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/dbuf_pwm_timebase.sv
module dbuf_pwm_timebase
    import dbuf_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  logic [TMR_W-1:0] period,
    output tbase_t           tb_q,
    output tbase_t           tb_next,
    output logic             roll,
    output logic             frame_q
);
    tb_state_t st_d, st_q;

    always_comb begin
        roll = run && step && (st_q.tb == {period, {SUB_W{1'b1}}});
        st_d = st_q;
        st_d.frame = roll;
        if (!run)      st_d.tb = '0;
        else if (roll) st_d.tb = '0;
        else if (step) st_d.tb = st_q.tb + 1'b1;
        tb_next = st_d.tb;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tb_q    = st_q.tb;
    assign frame_q = st_q.frame;

    a_r1_frame_at_zero: assert property (@(posedge clk) disable iff (rst)
        st_q.frame |-> st_q.tb == '0);
    a_r8_tb_idle: assert property (@(posedge clk) disable iff (rst)
        !run |=> (st_q.tb == '0 && !st_q.frame));
endmodule

// File: rtl/dbuf_pwm_outlatch.sv
module dbuf_pwm_outlatch
    import dbuf_pwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   roll,
    input  logic   frame,
    input  tbase_t tb_next,
    input  tbase_t duty,
    output tbase_t shadow_q,
    output logic   out_q
);
    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (roll) st_d.shadow = duty;
        if (!run)                        st_d.out = 1'b0;
        else if (roll)                   st_d.out = (duty != '0);
        else if (tb_next == st_q.shadow) st_d.out = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign shadow_q = st_q.shadow;
    assign out_q    = st_q.out;

    a_r5_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
        (st_q.shadow == '0) |-> !st_q.out);
    a_r7_shadow_held: assert property (@(posedge clk) disable iff (rst)
        !frame |-> $stable(st_q.shadow));
endmodule

// File: rtl/dbuf_pwm.sv
module dbuf_pwm
    import dbuf_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] mode_i,
    input  logic [1:0] prescale_i,
    input  logic [7:0] period_i,
    input  logic [7:0] duty_hi_i,
    input  logic [1:0] duty_lo_i,
    output logic       pwm_o,
    output logic       frame_o
);
    logic   run, step, roll;
    tbase_t tb_q, tb_next, shadow_q;

    assign run = (mode_i[3:2] == 2'b11);

    dbuf_pwm_prescaler u_presc (
        .clk(clk), .rst(rst), .run(run), .sel(prescale_i), .step(step)
    );

    dbuf_pwm_timebase u_tb (
        .clk(clk), .rst(rst), .run(run), .step(step), .period(period_i),
        .tb_q(tb_q), .tb_next(tb_next), .roll(roll), .frame_q(frame_o)
    );

    dbuf_pwm_outlatch u_latch (
        .clk(clk), .rst(rst), .run(run), .roll(roll), .frame(frame_o),
        .tb_next(tb_next), .duty({duty_hi_i, duty_lo_i}),
        .shadow_q(shadow_q), .out_q(pwm_o)
    );

    a_r3_set_at_start: assert property (@(posedge clk) disable iff (rst)
        (frame_o && shadow_q != '0) |-> pwm_o);
    a_r8_off_low: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!pwm_o && !frame_o));
endmodule

// File: tb/dbuf_pwm_bench.sv
module dbuf_pwm_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mode_i = 4'b0000;
    logic [1:0] prescale_i = 2'd0;
    logic [7:0] period_i = 8'd0;
    logic [7:0] duty_hi_i = 8'd0;
    logic [1:0] duty_lo_i = 2'd0;
    logic       pwm_o, frame_o;

    dbuf_pwm u_dbuf_pwm (
        .clk(clk), .rst(rst), .mode_i(mode_i), .prescale_i(prescale_i),
        .period_i(period_i), .duty_hi_i(duty_hi_i), .duty_lo_i(duty_lo_i),
        .pwm_o(pwm_o), .frame_o(frame_o)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    string tag = "R9";
    bit compare_on = 0;

    // reference model state
    int pos = 0, shadow = 0;
    bit started = 0, exp_out = 0, exp_frame = 0;

    function automatic int pfac(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : 16;
    endfunction

    always @(posedge clk) begin
        int len;
        cycles++;
        len = (int'(period_i) + 1) * 4 * pfac(prescale_i);
        if (rst) begin
            pos = 0; started = 0; shadow = 0; exp_out = 0; exp_frame = 0;
        end else if (mode_i[3:2] != 2'b11) begin
            pos = 0; started = 0; exp_out = 0; exp_frame = 0;
        end else begin
            pos = pos + 1;
            exp_frame = 0;
            if (pos >= len) begin
                pos = 0;
                shadow = {duty_hi_i, duty_lo_i};
                started = 1;
                exp_frame = 1;
            end
            exp_out = started && (pos < shadow * pfac(prescale_i));
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (compare_on) begin
            check(tag, pwm_o, exp_out, "pwm_o");
            check(tag, frame_o, exp_frame, "frame_o");
        end
    end

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [7:0] pr, input logic [1:0] ps, input int duty);
        @(negedge clk);
        mode_i = 4'b0000;
        clocks(2);
        period_i = pr; prescale_i = ps;
        duty_hi_i = 8'(duty >> 2); duty_lo_i = 2'(duty);
        mode_i = 4'b1100;
    endtask

    task automatic measure(input string req, input int exp_len, input int exp_high);
        int len, hi;
        len = 0; hi = 0;
        while (frame_o !== 1'b1) @(negedge clk);
        do begin
            if (pwm_o === 1'b1) hi++;
            len++;
            @(negedge clk);
        end while (frame_o !== 1'b1 && len < 5000);
        check_int(req, len, exp_len, "period length");
        check_int(req, hi, exp_high, "high time");
    endtask

    initial begin
        clocks(3);
        // R9: reset state
        check("R9", pwm_o, 1'b0, "pwm_o after reset");
        check("R9", frame_o, 1'b0, "frame_o after reset");
        rst = 1'b0;
        compare_on = 1;

        // R1 R3 R4 R8: prescale 1, period 4, duty 10 -> 20 clocks, 10 high
        tag = "R4";
        setup(8'd4, 2'd0, 10);
        clocks(25);
        measure("R1", 20, 10);
        clocks(30);

        // R2: prescale 4, period 2, duty 5 -> 48 clocks, 20 high
        tag = "R2";
        setup(8'd2, 2'd1, 5);
        measure("R2", 48, 20);
        clocks(60);

        // R2: code 3 -> 16, period 1, duty 3 -> 128 clocks, 48 high
        setup(8'd1, 2'd3, 3);
        measure("R2", 128, 48);
        clocks(130);

        // R2: code 2 -> 16
        setup(8'd0, 2'd2, 1);
        measure("R2", 64, 16);

        // R5: zero duty
        tag = "R5";
        setup(8'd3, 2'd0, 0);
        measure("R5", 16, 0);
        clocks(40);

        // R6: duty equal to and above the period span
        tag = "R6";
        setup(8'd4, 2'd0, 20);
        measure("R6", 20, 20);
        clocks(45);
        setup(8'd2, 2'd1, 1023);
        measure("R6", 48, 48);
        clocks(50);

        // R7: duty rewritten a few cycles into a period
        tag = "R7";
        setup(8'd7, 2'd0, 24);
        while (frame_o !== 1'b1) @(negedge clk);
        clocks(40);
        while (frame_o !== 1'b1) @(negedge clk);
        clocks(3);
        duty_hi_i = 8'd1; duty_lo_i = 2'd2;   // new duty 6
        clocks(29);
        measure("R7", 32, 6);
        clocks(70);

        // R8: disable while output is high, then re-enable
        tag = "R8";
        setup(8'd4, 2'd0, 15);
        while (frame_o !== 1'b1) @(negedge clk);
        clocks(3);
        mode_i = 4'b0100;
        clocks(6);
        check("R8", pwm_o, 1'b0, "pwm_o while disabled");
        mode_i = 4'b1100;
        clocks(10);
        check("R8", pwm_o, 1'b0, "pwm_o before first boundary");
        clocks(60);

        // R9: reset while running
        tag = "R9";
        rst = 1'b1;
        clocks(2);
        check("R9", pwm_o, 1'b0, "pwm_o in reset");
        rst = 1'b0;
        clocks(30);

        compare_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule